// File: doc/BRIEF.md
# Feature-Gated Integer Execute Unit

This block is the execute stage of a 32-bit RISC core. Each cycle it may accept one decoded operation, given as a 5-bit operation code, a flag that selects the register-immediate form, two 32-bit register operands, a 16-bit immediate and a 5-bit shift immediate. Most operations finish in one cycle: the unit registers a 32-bit result together with a done pulse and a write-enable for the destination register. The exceptions are unsigned divide and modulo. These run on a 32-step restoring divider and keep `busy` high while it works.

Four build-time switches set how much optional hardware is present: the multiplier, the divider, the barrel shifter and the sign extender. When a unit is left out, its operations end with the illegal-instruction flag set. One case is kept legal without the barrel shifter: a right shift by exactly one bit, which is cheap to build. The kind of immediate extension depends on the operation. A divisor of zero is reported through its own flag, and the destination is then not written. The register file, memory access and exception vectoring sit outside this block.

Top module: `exu_top`

## Requirements
- R1: While reset is asserted and in the first cycle after it is released, `busy`, `done`, `illegal`, `div_zero` and `wr_en` are 0 and `result` is 0.
- R2: An `issue` accepted while `busy` is low completes in the clock edge that samples it. From that edge on, `done` is high for one cycle, with `wr_en` set and `result` valid. Operation codes: 0 add, 1 sub, 2 and, 3 or, 4 xor, 5 nor, 6 xnor, 7 and-high, 8 or-high, 9 eq, 10 ne, 11 gt signed, 12 ge signed, 13 gt unsigned, 14 ge unsigned, 15 shift left, 16 shift right arithmetic, 17 shift right logical, 18 sign-extend byte, 19 sign-extend half, 20 mul, 21 divu, 22 modu, 23 to 31 unused. Sub, the sign extensions and divide/modulo always use the register form. Sign extension reads `opa`.
- R3: When `use_imm` is 1, add, mul, eq, ne, gt and ge take `imm16` sign-extended as the second operand. and, or, xor, nor, xnor, gt-unsigned and ge-unsigned take it zero-extended.
- R4: And-high and or-high always combine `opa` with `{imm16, 16'h0}`, whatever `use_imm` is.
- R5: The six compares return 1 when the relation holds and 0 when it does not. gt and ge compare as signed numbers; the unsigned forms compare as unsigned numbers.
- R6: The shift amount is `imm5` when `use_imm` is 1, and otherwise `opb[4:0]`. A left shift fills with zeros. The arithmetic right shift copies bit 31 into the vacated bits; the logical right shift fills them with zeros.
- R7: Without the barrel shifter, a left shift is illegal, and a right shift of either kind is illegal unless the shift amount is exactly 1.
- R8: mul returns the low 32 bits of the product. Byte and half-word sign extension copy bit 7 or bit 15 upward. mul is illegal without the multiplier, and both sign extensions are illegal without the sign extender.
- R9: The immediate form of nor returns `~(opa | zext(imm16))` and the immediate form of xnor returns `~(opa ^ zext(imm16))`.
- R10: A divu or modu with a nonzero divisor sets `busy` for 32 cycles starting at the issue edge. Thirty-two edges after the issue edge, `done` and `wr_en` pulse with the quotient (divu) or remainder (modu) of `opa` by `opb`.
- R11: A divu or modu with `opb` equal to 0 completes in one cycle with `div_zero` set, `wr_en` low and `result` 0, and does not set `busy`. Without the divider, both operations are illegal, and this check takes precedence over the zero check.
- R12: An illegal operation (unused code or missing hardware) completes in one cycle with `illegal` set, `wr_en` low and `result` 0.
- R13: An `issue` that arrives while `busy` is high is ignored: it produces no `done` and does not change the divide in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| issue | input | 1 | An operation is presented this cycle |
| op | input | 5 | Operation code (see R2) |
| use_imm | input | 1 | 1 selects the register-immediate form |
| opa | input | 32 | First register operand |
| opb | input | 32 | Second register operand |
| imm16 | input | 16 | 16-bit immediate |
| imm5 | input | 5 | Shift-amount immediate |
| busy | output | 1 | Divider is working; new issues are ignored |
| done | output | 1 | One-cycle completion pulse |
| result | output | 32 | Result; 0 unless a clean completion |
| wr_en | output | 1 | Destination register should be written |
| illegal | output | 1 | Completed operation was illegal |
| div_zero | output | 1 | Completed divide/modulo had a zero divisor |

## Verification
The bench builds two copies of the block side by side. In one, every optional unit is enabled; in the other, all four are disabled. Both copies receive the same stimulus. The fully equipped build exercises the barrel shifter, the multiplier and the 32-cycle divider, including issues that arrive while the divider is busy. The stripped build reaches every illegal-instruction path, the one-bit right shift that stays legal, and the rule that a disabled divider raises the illegal flag before any zero-divisor check.

// File: rtl/exu_pkg.sv
package exu_pkg;
  localparam int XLEN  = 32;
  localparam int SHW   = $clog2(XLEN);
  localparam int IMM_W = 16;
  localparam int OP_W  = 5;

  typedef enum logic [OP_W-1:0] {
    OP_ADD    = 5'd0,
    OP_SUB    = 5'd1,
    OP_AND    = 5'd2,
    OP_OR     = 5'd3,
    OP_XOR    = 5'd4,
    OP_NOR    = 5'd5,
    OP_XNOR   = 5'd6,
    OP_ANDHI  = 5'd7,
    OP_ORHI   = 5'd8,
    OP_CMPEQ  = 5'd9,
    OP_CMPNE  = 5'd10,
    OP_CMPGT  = 5'd11,
    OP_CMPGE  = 5'd12,
    OP_CMPGTU = 5'd13,
    OP_CMPGEU = 5'd14,
    OP_SHL    = 5'd15,
    OP_SHRA   = 5'd16,
    OP_SHRL   = 5'd17,
    OP_SEXTB  = 5'd18,
    OP_SEXTH  = 5'd19,
    OP_MUL    = 5'd20,
    OP_DIVU   = 5'd21,
    OP_MODU   = 5'd22
  } exu_op_e;

  typedef enum logic [1:0] {
    EXT_REG,
    EXT_SIGN,
    EXT_ZERO,
    EXT_HIGH
  } ext_mode_e;
endpackage

// File: rtl/exu_operand.sv
module exu_operand
  import exu_pkg::*;
(
  input  exu_op_e              op,
  input  logic                 use_imm,
  input  logic [XLEN-1:0]      opb,
  input  logic [IMM_W-1:0]     imm16,
  input  logic [SHW-1:0]       imm5,
  output logic [XLEN-1:0]      src_b,
  output logic [SHW-1:0]       shamt
);
  localparam int PAD_W = XLEN - IMM_W;

  ext_mode_e mode;

  // Immediate extension style is a property of the operation
  always_comb begin
    unique case (op)
      OP_ADD, OP_MUL, OP_CMPEQ, OP_CMPNE, OP_CMPGT, OP_CMPGE:
        mode = EXT_SIGN;
      OP_AND, OP_OR, OP_XOR, OP_NOR, OP_XNOR, OP_CMPGTU, OP_CMPGEU:
        mode = EXT_ZERO;
      OP_ANDHI, OP_ORHI:
        mode = EXT_HIGH;
      default:
        mode = EXT_REG;
    endcase
  end

  always_comb begin
    src_b = opb;
    if (mode == EXT_HIGH)
      src_b = {imm16, {PAD_W{1'b0}}};
    else if (use_imm && mode == EXT_SIGN)
      src_b = {{PAD_W{imm16[IMM_W-1]}}, imm16};
    else if (use_imm && mode == EXT_ZERO)
      src_b = {{PAD_W{1'b0}}, imm16};
  end

  assign shamt = use_imm ? imm5 : opb[SHW-1:0];
endmodule

// File: rtl/exu_alu.sv
module exu_alu
  import exu_pkg::*;
#(
  parameter bit EN_MUL   = 1'b1,
  parameter bit EN_SHIFT = 1'b1,
  parameter bit EN_SEXT  = 1'b1,
  parameter bit EN_DIV   = 1'b1
) (
  input  exu_op_e          op,
  input  logic [XLEN-1:0]  src_a,
  input  logic [XLEN-1:0]  src_b,
  input  logic [SHW-1:0]   shamt,
  output logic [XLEN-1:0]  res,
  output logic             illegal,
  output logic             div_op
);
  localparam logic [SHW-1:0] ONE_BIT = SHW'(1);

  logic [XLEN-1:0] shl_v, shra_v, shrl_v, mul_v;
  logic            shift_ok, right_ok;

  // Shifter: full barrel or the single-bit right shift only
  if (EN_SHIFT) begin : g_barrel
    assign shl_v    = src_a << shamt;
    assign shra_v   = XLEN'($signed(src_a) >>> shamt);
    assign shrl_v   = src_a >> shamt;
    assign shift_ok = 1'b1;
    assign right_ok = 1'b1;
  end else begin : g_onebit
    assign shl_v    = '0;
    assign shra_v   = {src_a[XLEN-1], src_a[XLEN-1:1]};
    assign shrl_v   = {1'b0, src_a[XLEN-1:1]};
    assign shift_ok = 1'b0;
    assign right_ok = (shamt == ONE_BIT);
  end

  if (EN_MUL) begin : g_mul
    assign mul_v = src_a * src_b;
  end else begin : g_nomul
    assign mul_v = '0;
  end

  logic eq_f, gt_s, gt_u;
  assign eq_f = (src_a == src_b);
  assign gt_s = ($signed(src_a) > $signed(src_b));
  assign gt_u = (src_a > src_b);

  always_comb begin
    res     = '0;
    illegal = 1'b0;
    div_op  = 1'b0;
    unique case (op)
      OP_ADD:    res = src_a + src_b;
      OP_SUB:    res = src_a - src_b;
      OP_AND:    res = src_a & src_b;
      OP_OR:     res = src_a | src_b;
      OP_XOR:    res = src_a ^ src_b;
      OP_NOR:    res = ~(src_a | src_b);
      OP_XNOR:   res = ~(src_a ^ src_b);
      OP_ANDHI:  res = src_a & src_b;
      OP_ORHI:   res = src_a | src_b;
      OP_CMPEQ:  res = XLEN'(eq_f);
      OP_CMPNE:  res = XLEN'(!eq_f);
      OP_CMPGT:  res = XLEN'(gt_s);
      OP_CMPGE:  res = XLEN'(gt_s | eq_f);
      OP_CMPGTU: res = XLEN'(gt_u);
      OP_CMPGEU: res = XLEN'(gt_u | eq_f);
      OP_SHL: begin
        res     = shl_v;
        illegal = !shift_ok;
      end
      OP_SHRA: begin
        res     = shra_v;
        illegal = !right_ok;
      end
      OP_SHRL: begin
        res     = shrl_v;
        illegal = !right_ok;
      end
      OP_SEXTB: begin
        res     = {{(XLEN-8){src_a[7]}}, src_a[7:0]};
        illegal = !EN_SEXT;
      end
      OP_SEXTH: begin
        res     = {{(XLEN-16){src_a[15]}}, src_a[15:0]};
        illegal = !EN_SEXT;
      end
      OP_MUL: begin
        res     = mul_v;
        illegal = !EN_MUL;
      end
      OP_DIVU, OP_MODU: begin
        div_op  = EN_DIV;
        illegal = !EN_DIV;
      end
      default: illegal = 1'b1;
    endcase
    if (illegal) res = '0;
  end
endmodule

// File: rtl/exu_divider.sv
module exu_divider
  import exu_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             want_rem,
  input  logic [XLEN-1:0]  dividend,
  input  logic [XLEN-1:0]  divisor,
  output logic             busy,
  output logic             last,
  output logic [XLEN-1:0]  res_next
);
  localparam int CNT_W = SHW + 1;
  localparam logic [CNT_W-1:0] STEPS = CNT_W'(XLEN);

  logic             busy_q, busy_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [XLEN-1:0]  rem_q, rem_d, quo_q, quo_d, dvs_q, dvs_d;
  logic             mode_q, mode_d;
  logic             en;

  // One restoring step: shift in the next dividend bit, trial-subtract
  logic [XLEN:0]   part, diff;
  logic            fits;
  logic [XLEN-1:0] rem_step, quo_step;

  always_comb begin
    part     = {rem_q, quo_q[XLEN-1]};
    diff     = part - {1'b0, dvs_q};
    fits     = !diff[XLEN];
    rem_step = fits ? diff[XLEN-1:0] : part[XLEN-1:0];
    quo_step = {quo_q[XLEN-2:0], fits};
  end

  assign last     = busy_q && (cnt_q == CNT_W'(1));
  assign busy     = busy_q;
  assign res_next = mode_q ? rem_step : quo_step;
  assign en       = start | busy_q;

  always_comb begin
    busy_d = busy_q;
    cnt_d  = cnt_q;
    rem_d  = rem_q;
    quo_d  = quo_q;
    dvs_d  = dvs_q;
    mode_d = mode_q;
    if (start) begin
      busy_d = 1'b1;
      cnt_d  = STEPS;
      rem_d  = '0;
      quo_d  = dividend;
      dvs_d  = divisor;
      mode_d = want_rem;
    end else if (busy_q) begin
      rem_d  = rem_step;
      quo_d  = quo_step;
      cnt_d  = cnt_q - CNT_W'(1);
      busy_d = !last;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
      rem_q  <= '0;
      quo_q  <= '0;
      dvs_q  <= '0;
      mode_q <= 1'b0;
    end else if (en) begin
      busy_q <= busy_d;
      cnt_q  <= cnt_d;
      rem_q  <= rem_d;
      quo_q  <= quo_d;
      dvs_q  <= dvs_d;
      mode_q <= mode_d;
    end
  end

  // R13: the controller never restarts a running divide
  assert_no_restart_R13: assert property (@(posedge clk) disable iff (!rst_n)
    start |-> !busy_q);
  // R10: busy persists until the final step
  assert_busy_holds_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && !last) |=> busy_q);
  // R10: the final step releases busy
  assert_last_ends_R10: assert property (@(posedge clk) disable iff (!rst_n)
    last |=> !busy_q);
endmodule

// File: rtl/exu_top.sv
module exu_top
  import exu_pkg::*;
#(
  parameter bit EN_MUL   = 1'b1,
  parameter bit EN_DIV   = 1'b1,
  parameter bit EN_SHIFT = 1'b1,
  parameter bit EN_SEXT  = 1'b1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              issue,
  input  logic [OP_W-1:0]   op,
  input  logic              use_imm,
  input  logic [XLEN-1:0]   opa,
  input  logic [XLEN-1:0]   opb,
  input  logic [IMM_W-1:0]  imm16,
  input  logic [SHW-1:0]    imm5,
  output logic              busy,
  output logic              done,
  output logic [XLEN-1:0]   result,
  output logic              wr_en,
  output logic              illegal,
  output logic              div_zero
);
  exu_op_e         op_e;
  logic [XLEN-1:0] src_b, alu_res, div_res;
  logic [SHW-1:0]  shamt;
  logic            alu_ill, div_op;
  logic            div_busy, div_last, div_start, accept;

  assign op_e = exu_op_e'(op);

  exu_operand u_operand (
    .op      (op_e),
    .use_imm (use_imm),
    .opb     (opb),
    .imm16   (imm16),
    .imm5    (imm5),
    .src_b   (src_b),
    .shamt   (shamt)
  );

  exu_alu #(
    .EN_MUL   (EN_MUL),
    .EN_SHIFT (EN_SHIFT),
    .EN_SEXT  (EN_SEXT),
    .EN_DIV   (EN_DIV)
  ) u_alu (
    .op      (op_e),
    .src_a   (opa),
    .src_b   (src_b),
    .shamt   (shamt),
    .res     (alu_res),
    .illegal (alu_ill),
    .div_op  (div_op)
  );

  assign accept    = issue && !div_busy;
  assign div_start = accept && div_op && (opb != '0);

  if (EN_DIV) begin : g_div
    exu_divider u_div (
      .clk      (clk),
      .rst_n    (rst_n),
      .start    (div_start),
      .want_rem (op_e == OP_MODU),
      .dividend (opa),
      .divisor  (opb),
      .busy     (div_busy),
      .last     (div_last),
      .res_next (div_res)
    );
  end else begin : g_nodiv
    assign div_busy = 1'b0;
    assign div_last = 1'b0;
    assign div_res  = '0;
  end

  // Completion registers
  logic            done_q, done_d, wr_q, wr_d, ill_q, ill_d, dz_q, dz_d;
  logic [XLEN-1:0] res_q, res_d;
  logic            out_en;

  always_comb begin
    done_d = 1'b0;
    wr_d   = 1'b0;
    ill_d  = 1'b0;
    dz_d   = 1'b0;
    res_d  = '0;
    if (div_last) begin
      done_d = 1'b1;
      wr_d   = 1'b1;
      res_d  = div_res;
    end else if (accept) begin
      if (alu_ill) begin
        done_d = 1'b1;
        ill_d  = 1'b1;
      end else if (div_op) begin
        if (opb == '0) begin
          done_d = 1'b1;
          dz_d   = 1'b1;
        end
      end else begin
        done_d = 1'b1;
        wr_d   = 1'b1;
        res_d  = alu_res;
      end
    end
  end

  assign out_en = accept | div_last | done_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      done_q <= 1'b0;
      wr_q   <= 1'b0;
      ill_q  <= 1'b0;
      dz_q   <= 1'b0;
      res_q  <= '0;
    end else if (out_en) begin
      done_q <= done_d;
      wr_q   <= wr_d;
      ill_q  <= ill_d;
      dz_q   <= dz_d;
      res_q  <= res_d;
    end
  end

  assign busy     = div_busy;
  assign done     = done_q;
  assign result   = res_q;
  assign wr_en    = wr_q;
  assign illegal  = ill_q;
  assign div_zero = dz_q;

  // R12: a write is only requested for a clean completion
  assert_wr_clean_R12: assert property (@(posedge clk) disable iff (!rst_n)
    wr_q |-> (done_q && !ill_q && !dz_q));
  // R11: zero divisor reports in one cycle without starting the divider
  assert_div_zero_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (EN_DIV && issue && !div_busy && (op_e == OP_DIVU || op_e == OP_MODU) && opb == '0)
      |=> (dz_q && done_q && !div_busy));
  // R7: left shift without a barrel shifter is illegal
  assert_shl_illegal_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!EN_SHIFT && issue && !div_busy && op_e == OP_SHL) |=> ill_q);
  // R13: an issue during a running divide produces no completion
  assert_busy_ignored_R13: assert property (@(posedge clk) disable iff (!rst_n)
    (issue && div_busy && !div_last) |=> !done_q);
  // R3: zero-extended logical immediates leave the upper half clear
  assert_and_imm_zext_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (issue && !div_busy && use_imm && op_e == OP_AND) |=> (result[XLEN-1:IMM_W] == '0));
  // R10: an accepted divide raises busy
  assert_div_busy_R10: assert property (@(posedge clk) disable iff (!rst_n)
    div_start |=> div_busy);
endmodule

// File: tb/exu_top_tb.sv
module exu_top_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        issue = 1'b0;
  logic [4:0]  op = '0;
  logic        use_imm = 1'b0;
  logic [31:0] opa = '0, opb = '0;
  logic [15:0] imm16 = '0;
  logic [4:0]  imm5 = '0;

  logic [1:0]  o_busy, o_done, o_wr, o_ill, o_dz;
  logic [31:0] o_res [2];

  always #4 clk = ~clk;

  exu_top #(.EN_MUL(1'b1), .EN_DIV(1'b1), .EN_SHIFT(1'b1), .EN_SEXT(1'b1)) u_dut (
    .clk(clk), .rst_n(rst_n), .issue(issue), .op(op), .use_imm(use_imm),
    .opa(opa), .opb(opb), .imm16(imm16), .imm5(imm5),
    .busy(o_busy[0]), .done(o_done[0]), .result(o_res[0]), .wr_en(o_wr[0]),
    .illegal(o_ill[0]), .div_zero(o_dz[0]));

  exu_top #(.EN_MUL(1'b0), .EN_DIV(1'b0), .EN_SHIFT(1'b0), .EN_SEXT(1'b0)) u_min (
    .clk(clk), .rst_n(rst_n), .issue(issue), .op(op), .use_imm(use_imm),
    .opa(opa), .opb(opb), .imm16(imm16), .imm5(imm5),
    .busy(o_busy[1]), .done(o_done[1]), .result(o_res[1]), .wr_en(o_wr[1]),
    .illegal(o_ill[1]), .div_zero(o_dz[1]));

  int    checks = 0;
  int    fails = 0;
  int    cycles = 0;
  bit    finished = 1'b0;
  string cur_req = "R1";

  // kind: 0 clean, 1 illegal, 2 zero divisor, 3 long divide
  function automatic void calc(input logic [4:0] f_op, input logic ui,
      input logic [31:0] a, input logic [31:0] b, input logic [15:0] i16,
      input logic [4:0] i5, input bit full,
      output logic [1:0] kind, output logic [31:0] r);
    logic [31:0] sx, zx, bs, bz;
    logic [4:0]  sh;
    sx = {{16{i16[15]}}, i16};
    zx = {16'h0, i16};
    bs = ui ? sx : b;
    bz = ui ? zx : b;
    sh = ui ? i5 : b[4:0];
    kind = 2'd0;
    r = 32'h0;
    case (f_op)
      5'd0:  r = a + bs;
      5'd1:  r = a - b;
      5'd2:  r = a & bz;
      5'd3:  r = a | bz;
      5'd4:  r = a ^ bz;
      5'd5:  r = ~(a | bz);
      5'd6:  r = ~(a ^ bz);
      5'd7:  r = a & {i16, 16'h0};
      5'd8:  r = a | {i16, 16'h0};
      5'd9:  r = {31'h0, a == bs};
      5'd10: r = {31'h0, a != bs};
      5'd11: r = {31'h0, $signed(a) > $signed(bs)};
      5'd12: r = {31'h0, $signed(a) >= $signed(bs)};
      5'd13: r = {31'h0, a > bz};
      5'd14: r = {31'h0, a >= bz};
      5'd15: if (!full) kind = 2'd1; else r = a << sh;
      5'd16: if (!full && sh != 5'd1) kind = 2'd1; else r = $signed(a) >>> sh;
      5'd17: if (!full && sh != 5'd1) kind = 2'd1; else r = a >> sh;
      5'd18: if (!full) kind = 2'd1; else r = {{24{a[7]}}, a[7:0]};
      5'd19: if (!full) kind = 2'd1; else r = {{16{a[15]}}, a[15:0]};
      5'd20: if (!full) kind = 2'd1; else r = a * bs;
      5'd21, 5'd22: begin
        if (!full) kind = 2'd1;
        else if (b == 32'h0) kind = 2'd2;
        else begin
          kind = 2'd3;
          r = (f_op == 5'd21) ? a / b : a % b;
        end
      end
      default: kind = 2'd1;
    endcase
    if (kind != 2'd0) r = (kind == 2'd3) ? r : 32'h0;
  endfunction

  // Behavioural reference per build: index 0 full, index 1 stripped
  int          cnt [2];
  logic [31:0] pend [2];
  logic        e_busy [2], e_done [2], e_wr [2], e_ill [2], e_dz [2];
  logic [31:0] e_res [2];

  always @(posedge clk or negedge rst_n) begin
    for (int k = 0; k < 2; k++) begin
      if (!rst_n) begin
        cnt[k] = 0; pend[k] = 0;
        e_busy[k] = 0; e_done[k] = 0; e_wr[k] = 0; e_ill[k] = 0; e_dz[k] = 0;
        e_res[k] = 0;
      end else begin
        logic [1:0]  kd;
        logic [31:0] rv;
        e_done[k] = 0; e_wr[k] = 0; e_ill[k] = 0; e_dz[k] = 0; e_res[k] = 0;
        if (cnt[k] > 0) begin
          cnt[k] = cnt[k] - 1;
          if (cnt[k] == 0) begin
            e_done[k] = 1; e_wr[k] = 1; e_res[k] = pend[k];
          end
        end else if (issue) begin
          calc(op, use_imm, opa, opb, imm16, imm5, (k == 0), kd, rv);
          case (kd)
            2'd0: begin e_done[k] = 1; e_wr[k] = 1; e_res[k] = rv; end
            2'd1: begin e_done[k] = 1; e_ill[k] = 1; end
            2'd2: begin e_done[k] = 1; e_dz[k] = 1; end
            default: begin cnt[k] = 32; pend[k] = rv; end
          endcase
        end
        e_busy[k] = (cnt[k] > 0);
      end
    end
  end

  always @(negedge clk) begin
    if (!finished) begin
      for (int k = 0; k < 2; k++) begin
        checks++;
        if ({o_busy[k], o_done[k], o_wr[k], o_ill[k], o_dz[k], o_res[k]} !==
            {e_busy[k], e_done[k], e_wr[k], e_ill[k], e_dz[k], e_res[k]}) begin
          fails++;
          $display("FAIL %s build%0d: actual busy=%b done=%b wr=%b ill=%b dz=%b res=%h expected busy=%b done=%b wr=%b ill=%b dz=%b res=%h",
            cur_req, k, o_busy[k], o_done[k], o_wr[k], o_ill[k], o_dz[k], o_res[k],
            e_busy[k], e_done[k], e_wr[k], e_ill[k], e_dz[k], e_res[k]);
        end
      end
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000 && !finished) begin
      fails++;
      $display("FAIL watchdog: actual cycles=%0d expected below 20000", cycles);
      finished = 1'b1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  task automatic idle(input int n);
    repeat (n) @(posedge clk);
  endtask

  task automatic send(input string req, input logic [4:0] s_op, input logic ui,
      input logic [31:0] a, input logic [31:0] b, input logic [15:0] i16,
      input logic [4:0] i5);
    @(posedge clk); #2;
    cur_req = req;
    issue = 1'b1; op = s_op; use_imm = ui; opa = a; opb = b; imm16 = i16; imm5 = i5;
    @(posedge clk); #2;
    issue = 1'b0;
  endtask

  initial begin
    idle(3); #2;
    rst_n = 1'b1;
    idle(2);
    // R2 register forms
    send("R2", 5'd0, 0, 32'd5, 32'd7, 16'h0, 5'd0);
    send("R2", 5'd1, 0, 32'd3, 32'd10, 16'h0, 5'd0);
    send("R2", 5'd4, 0, 32'hF0F0_1234, 32'h0FF0_FFFF, 16'h0, 5'd0);
    idle(1);
    // R3 immediate extension
    send("R3", 5'd0, 1, 32'd100, 32'h0, 16'hFFFF, 5'd0);
    send("R3", 5'd2, 1, 32'hFFFF_FFFF, 32'h0, 16'hFFFF, 5'd0);
    send("R3", 5'd13, 1, 32'h0000_9000, 32'h0, 16'h8000, 5'd0);
    send("R3", 5'd11, 1, 32'd5, 32'h0, 16'h8000, 5'd0);
    send("R3", 5'd14, 1, 32'h0000_8000, 32'h0, 16'h8000, 5'd0);
    send("R3", 5'd20, 1, 32'd7, 32'h0, 16'hFFFE, 5'd0);
    // R4 high-half ops
    send("R4", 5'd7, 0, 32'h1234_5678, 32'h0, 16'hFF00, 5'd0);
    send("R4", 5'd8, 1, 32'h0000_0001, 32'h0, 16'hABCD, 5'd0);
    // R5 compares, signed against unsigned
    for (int c = 9; c <= 14; c++) send("R5", 5'(c), 0, 32'hFFFF_FFFF, 32'd1, 16'h0, 5'd0);
    for (int c = 9; c <= 14; c++) send("R5", 5'(c), 0, 32'd42, 32'd42, 16'h0, 5'd0);
    // R6 shifts; register amount uses low five bits only
    send("R6", 5'd15, 0, 32'h0000_0003, 32'd33, 16'h0, 5'd0);
    send("R6", 5'd16, 0, 32'h8000_0000, 32'd4, 16'h0, 5'd0);
    send("R6", 5'd17, 0, 32'h8000_0000, 32'd4, 16'h0, 5'd0);
    send("R6", 5'd16, 1, 32'h8000_00F0, 32'd0, 16'h0, 5'd31);
    // R7 stripped shifter: one-bit right shifts stay legal
    send("R7", 5'd16, 1, 32'h8000_0002, 32'd0, 16'h0, 5'd1);
    send("R7", 5'd17, 0, 32'h8000_0002, 32'd33, 16'h0, 5'd0);
    send("R7", 5'd17, 1, 32'h8000_0002, 32'd0, 16'h0, 5'd2);
    send("R7", 5'd15, 1, 32'h1, 32'd0, 16'h0, 5'd1);
    // R8 multiply and sign extension
    send("R8", 5'd20, 0, 32'h0001_0000, 32'h0001_0000, 16'h0, 5'd0);
    send("R8", 5'd20, 0, 32'h1234_5678, 32'h9ABC_DEF1, 16'h0, 5'd0);
    send("R8", 5'd18, 0, 32'h1234_5680, 32'h0, 16'h0, 5'd0);
    send("R8", 5'd19, 0, 32'h0000_8001, 32'h0, 16'h0, 5'd0);
    // R9 inverted immediate logic
    send("R9", 5'd6, 1, 32'hFFFF_00FF, 32'h0, 16'h0F0F, 5'd0);
    send("R9", 5'd5, 1, 32'h0000_1000, 32'h0, 16'h00FF, 5'd0);
    // R10 long divide
    send("R10", 5'd21, 0, 32'd100, 32'd7, 16'h0, 5'd0);
    idle(34);
    send("R10", 5'd22, 0, 32'd100, 32'd7, 16'h0, 5'd0);
    idle(34);
    send("R10", 5'd21, 0, 32'hFFFF_FFFF, 32'd1, 16'h0, 5'd0);
    idle(34);
    send("R10", 5'd22, 0, 32'h0000_0005, 32'hFFFF_FFFF, 16'h0, 5'd0);
    idle(34);
    // R11 zero divisor
    send("R11", 5'd21, 0, 32'd9, 32'd0, 16'h0, 5'd0);
    send("R11", 5'd22, 0, 32'd9, 32'd0, 16'h0, 5'd0);
    idle(2);
    // R12 unused codes
    send("R12", 5'd25, 0, 32'd1, 32'd2, 16'h0, 5'd0);
    send("R12", 5'd31, 1, 32'd1, 32'd2, 16'h1, 5'd1);
    idle(2);
    // R13 issues during a running divide are dropped
    send("R13", 5'd21, 0, 32'd1000, 32'd10, 16'h0, 5'd0);
    send("R13", 5'd0, 0, 32'd1, 32'd1, 16'h0, 5'd0);
    idle(10);
    send("R13", 5'd21, 0, 32'd5, 32'd0, 16'h0, 5'd0);
    idle(30);
    send("R13", 5'd0, 0, 32'd2, 32'd2, 16'h0, 5'd0);
    idle(3);
    finished = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule